// File: doc/BRIEF.md
# Protocol Timer with Deferred Start and Stop

This block is a free-running 16-bit timer for timing medium-access protocol events. While it runs it counts up each fast clock cycle. When the count reaches a programmable period it wraps to zero and advances a 24-bit overflow counter. Three sticky event flags are raised by hardware: a byte-compare match, a period wrap, and an overflow-counter match. The single interrupt output is high while any flag is set.

Software uses a byte-wide register port to program the block and to read it back. One configuration register holds the flags, the compare-byte select, a synchronise-enable bit and the run bit. When synchronisation is off, a start or stop takes effect on the write itself. When it is on, the request waits for the next rising edge of a slow 32.768 kHz reference, and the run readback keeps the old state until that edge. On every start, the count and the overflow counter are loaded from values that software wrote earlier.

Top module: `mac_tmr`

## Requirements
- R1: After reset, the configuration register (address 0) reads 0x02: sync enabled and everything else 0. The count reads 0 and irq is low.
- R2: The flags in the configuration register are compare at bit 7, period at bit 6 and overflow-compare at bit 5. Each stays set until a configuration write puts a 0 in its bit. Writing a 1 to a flag bit leaves it unchanged.
- R3: Configuration bits 4 and 2 always read 0, whatever value was written to them.
- R4: With sync-enable (bit 1) at 0 in the written value, the write itself starts the timer (run bit 0 = 1) or stops it (run bit 0 = 0). The run bit reads the new state in the next cycle.
- R5: With sync-enable at 1, a start or stop is held until the first rising edge of slow_ref, seen through a two-flop synchroniser, and the run readback keeps the old state until then.
- R6: Each start event loads the count from the load value at addresses 1 (low byte) and 2 (high byte). It also loads the overflow counter from addresses 6, 7 and 8 (low to high). Reads of those addresses return the live values.
- R7: While running, the count increments each cycle. When it equals the period register (address 4 low, address 5 high; resets to 0xFFFF), it wraps to 0 on the next cycle, sets the period flag and increments the overflow counter.
- R8: While running, the compare flag is set when the selected count byte equals the compare register (address 3). Compare-select (bit 3) = 0 selects count bits 15:8, and 1 selects bits 7:0.
- R9: The overflow-compare flag is set on a wrap that takes the overflow counter to the value at addresses 9, 10 and 11 (low to high).
- R10: irq is the OR of the three flags.
- R11: While idle, the count and the overflow counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_ref | input | 1 | 32.768 kHz reference, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The hardest case to reach is the window between a synchronised start or stop request and the slow-reference edge that carries it out. Here the run readback has to disagree with the value just written. The bench waits for a slow_ref rise and then writes a few cycles later, so the next synchronised edge is still many cycles away. It reads the run bit inside that window and again after the edge. Short periods and small compare values make wraps, overflow matches and both compare-byte selections happen within a few dozen cycles. A cycle-accurate model checks the read data and irq on every clock.

// File: rtl/mac_tmr_pkg.sv
package mac_tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned CFG_RUN   = 0;
  localparam int unsigned CFG_SYNC  = 1;
  localparam int unsigned CFG_CMSEL = 3;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

  // flag vector order matches configuration bits 7:5
  typedef struct packed {
    logic cmp;
    logic per;
    logic ofc;
  } tmr_flags_t;
endpackage

// File: rtl/mac_tmr_refsync.sv
module mac_tmr_refsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise_o
);
  logic [STAGES:0] shift_q;
  logic [STAGES:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-1:0], ref_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/mac_tmr_runctl.sv
module mac_tmr_runctl
  import mac_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic wr_run,
  input  logic wr_sync,
  input  logic sync_q,
  input  logic ref_rise,
  output logic running,
  output logic start_evt
);
  run_state_e state_q, state_d;
  logic       req_q, req_d;
  logic       sync_now, apply;

  always_comb begin
    req_d    = cfg_wr ? wr_run  : req_q;
    sync_now = cfg_wr ? wr_sync : sync_q;
    apply    = !sync_now || ref_rise;
    state_d  = state_q;
    if (apply) state_d = req_d ? ST_RUN : ST_IDLE;
  end

  assign start_evt = (state_q == ST_IDLE) && (state_d == ST_RUN);
  assign running   = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && sync_q && !ref_rise) |=> $stable(running)); // R5
  AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wr_sync) |=> (running == $past(wr_run))); // R4
endmodule

// File: rtl/mac_tmr_core.sv
module mac_tmr_core
  import mac_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OVF_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [OVF_W-1:0]  ld_ovf,
  input  logic [CNT_W-1:0]  period,
  input  logic [BYTE_W-1:0] cmp_val,
  input  logic              cmp_low,
  input  logic [OVF_W-1:0]  ovf_cmp,
  output logic [CNT_W-1:0]  cnt,
  output logic [OVF_W-1:0]  ovf,
  output tmr_flags_t        evt
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OVF_W-1:0]  ovf_q, ovf_d, ovf_inc;
  logic [BYTE_W-1:0] sel_byte;
  logic              wrap, cnt_en;

  always_comb begin
    ovf_inc  = ovf_q + OVF_W'(1);
    sel_byte = cmp_low ? cnt_q[BYTE_W-1:0] : cnt_q[CNT_W-1 -: BYTE_W];
    wrap     = run && (cnt_q == period);
    evt.per  = wrap;
    evt.ofc  = wrap && (ovf_inc == ovf_cmp);
    evt.cmp  = run && (sel_byte == cmp_val);
    cnt_en   = run || load;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    if (load) begin
      cnt_d = ld_cnt;
      ovf_d = ld_ovf;
    end else if (wrap) begin
      cnt_d = '0;
      ovf_d = ovf_inc;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q == period) |=> (cnt_q == '0)); // R7
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q == period) |=> (ovf_q == $past(ovf_q) + OVF_W'(1))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> ($stable(cnt_q) && $stable(ovf_q))); // R11
endmodule

// File: rtl/mac_tmr.sv
module mac_tmr
  import mac_tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned OVF_W       = 24,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_ref,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int CNT_B  = CNT_W / BYTE_W;
  localparam int OVF_B  = OVF_W / BYTE_W;
  localparam int A_CFG  = 0;
  localparam int A_CNT  = 1;
  localparam int A_CMP  = A_CNT + CNT_B;
  localparam int A_PER  = A_CMP + 1;
  localparam int A_OVF  = A_PER + CNT_B;
  localparam int A_OCMP = A_OVF + OVF_B;

  tmr_flags_t        flag_q, flag_d, evt;
  logic              cmsel_q, cmsel_d, sync_q, sync_d;
  logic [BYTE_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0]  per_q, per_d, ldc_q, ldc_d, cnt;
  logic [OVF_W-1:0]  ocmp_q, ocmp_d, ldo_q, ldo_d, ovf;
  logic              cfg_wr, ref_rise, running, start_evt;

  assign cfg_wr = bus_wr && (bus_addr == ADDR_W'(A_CFG));

  mac_tmr_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(slow_ref), .rise_o(ref_rise)
  );

  mac_tmr_runctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .wr_run(bus_wdata[CFG_RUN]), .wr_sync(bus_wdata[CFG_SYNC]),
    .sync_q(sync_q), .ref_rise(ref_rise),
    .running(running), .start_evt(start_evt)
  );

  mac_tmr_core #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(running), .load(start_evt),
    .ld_cnt(ldc_q), .ld_ovf(ldo_q), .period(per_q), .cmp_val(cmp_q),
    .cmp_low(cmsel_q), .ovf_cmp(ocmp_q),
    .cnt(cnt), .ovf(ovf), .evt(evt)
  );

  always_comb begin
    flag_d  = (cfg_wr ? (flag_q & tmr_flags_t'(bus_wdata[7:5])) : flag_q) | evt;
    cmsel_d = cmsel_q;
    sync_d  = sync_q;
    cmp_d   = cmp_q;
    per_d   = per_q;
    ldc_d   = ldc_q;
    ocmp_d  = ocmp_q;
    ldo_d   = ldo_q;
    if (cfg_wr) begin
      cmsel_d = bus_wdata[CFG_CMSEL];
      sync_d  = bus_wdata[CFG_SYNC];
    end
    if (bus_wr && bus_addr == ADDR_W'(A_CMP)) cmp_d = bus_wdata;
    for (int i = 0; i < CNT_B; i++) begin
      if (bus_wr && bus_addr == ADDR_W'(A_CNT + i)) ldc_d[BYTE_W*i +: BYTE_W] = bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(A_PER + i)) per_d[BYTE_W*i +: BYTE_W] = bus_wdata;
    end
    for (int i = 0; i < OVF_B; i++) begin
      if (bus_wr && bus_addr == ADDR_W'(A_OVF + i))  ldo_d[BYTE_W*i +: BYTE_W]  = bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(A_OCMP + i)) ocmp_d[BYTE_W*i +: BYTE_W] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      cmsel_q <= 1'b0;
      sync_q  <= 1'b1;
      cmp_q   <= '0;
      per_q   <= '1;
      ldc_q   <= '0;
      ocmp_q  <= '0;
      ldo_q   <= '0;
    end else begin
      flag_q  <= flag_d;
      cmsel_q <= cmsel_d;
      sync_q  <= sync_d;
      cmp_q   <= cmp_d;
      per_q   <= per_d;
      ldc_q   <= ldc_d;
      ocmp_q  <= ocmp_d;
      ldo_q   <= ldo_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CFG))
      bus_rdata = {flag_q, 1'b0, cmsel_q, 1'b0, sync_q, running};
    if (bus_addr == ADDR_W'(A_CMP)) bus_rdata = cmp_q;
    for (int i = 0; i < CNT_B; i++) begin
      if (bus_addr == ADDR_W'(A_CNT + i)) bus_rdata = cnt[BYTE_W*i +: BYTE_W];
      if (bus_addr == ADDR_W'(A_PER + i)) bus_rdata = per_q[BYTE_W*i +: BYTE_W];
    end
    for (int i = 0; i < OVF_B; i++) begin
      if (bus_addr == ADDR_W'(A_OVF + i))  bus_rdata = ovf[BYTE_W*i +: BYTE_W];
      if (bus_addr == ADDR_W'(A_OCMP + i)) bus_rdata = ocmp_q[BYTE_W*i +: BYTE_W];
    end
  end

  assign irq = |flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2
  AST_CFG_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_CFG)) |-> (bus_rdata[4] == 1'b0 && bus_rdata[2] == 1'b0)); // R3
  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_CFG)) |-> (irq == |bus_rdata[7:5])); // R10
endmodule

// File: tb/mac_tmr_test.sv
module mac_tmr_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_HALF  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_ref = 1'b0;
  logic       slow_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mac_tmr uut (
    .clk(clk), .rst_n(rst_n), .slow_ref(slow_ref), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (SLOW_HALF) @(posedge clk);
      #1;
      if (slow_en) slow_ref = ~slow_ref;
    end
  end

  // behavioural reference model
  bit        m_run, m_req, m_sync, m_cmsel;
  bit [2:0]  m_flags;
  bit [7:0]  m_cmp;
  bit [15:0] m_per, m_ldc, m_cnt;
  bit [23:0] m_ocmp, m_ldo, m_ovf;
  bit        hist[$];

  function automatic bit [7:0] m_read(input bit [3:0] a);
    case (a)
      4'd0:  return {m_flags, 1'b0, m_cmsel, 1'b0, m_sync, m_run};
      4'd1:  return m_cnt[7:0];
      4'd2:  return m_cnt[15:8];
      4'd3:  return m_cmp;
      4'd4:  return m_per[7:0];
      4'd5:  return m_per[15:8];
      4'd6:  return m_ovf[7:0];
      4'd7:  return m_ovf[15:8];
      4'd8:  return m_ovf[23:16];
      4'd9:  return m_ocmp[7:0];
      4'd10: return m_ocmp[15:8];
      4'd11: return m_ocmp[23:16];
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_req = 0; m_sync = 1; m_cmsel = 0; m_flags = 0;
      m_cmp = 0; m_per = 16'hFFFF; m_ldc = 0; m_cnt = 0;
      m_ocmp = 0; m_ldo = 0; m_ovf = 0;
      hist = {1'b0, 1'b0, 1'b0};
    end else begin
      bit strobe, wcfg, tgt, syn;
      bit [2:0] set;
      bit [7:0] sel;
      bit [15:0] ncnt;
      bit [23:0] novf;
      bit nrun;
      strobe = hist[1] && !hist[2];
      hist.push_front(slow_ref);
      void'(hist.pop_back());
      wcfg = bus_wr && bus_addr == 4'd0;
      tgt  = wcfg ? bus_wdata[0] : m_req;
      syn  = wcfg ? bus_wdata[1] : m_sync;
      set = 0; ncnt = m_cnt; novf = m_ovf; nrun = m_run;
      if (m_run) begin
        sel = m_cmsel ? m_cnt[7:0] : m_cnt[15:8];
        if (sel == m_cmp) set[2] = 1;
        if (m_cnt == m_per) begin
          set[1] = 1;
          novf = m_ovf + 24'd1;
          if (novf == m_ocmp) set[0] = 1;
          ncnt = 0;
        end else ncnt = m_cnt + 16'd1;
      end
      if ((!syn || strobe) && tgt != m_run) begin
        if (tgt) begin ncnt = m_ldc; novf = m_ldo; end
        nrun = tgt;
      end
      m_flags = (wcfg ? (m_flags & bus_wdata[7:5]) : m_flags) | set;
      if (wcfg) begin m_cmsel = bus_wdata[3]; m_sync = bus_wdata[1]; end
      if (bus_wr) begin
        case (bus_addr)
          4'd1:  m_ldc[7:0]    = bus_wdata;
          4'd2:  m_ldc[15:8]   = bus_wdata;
          4'd3:  m_cmp         = bus_wdata;
          4'd4:  m_per[7:0]    = bus_wdata;
          4'd5:  m_per[15:8]   = bus_wdata;
          4'd6:  m_ldo[7:0]    = bus_wdata;
          4'd7:  m_ldo[15:8]   = bus_wdata;
          4'd8:  m_ldo[23:16]  = bus_wdata;
          4'd9:  m_ocmp[7:0]   = bus_wdata;
          4'd10: m_ocmp[15:8]  = bus_wdata;
          4'd11: m_ocmp[23:16] = bus_wdata;
          default: ;
        endcase
      end
      m_req = tgt; m_run = nrun; m_cnt = ncnt; m_ovf = novf;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("model(R7) rdata", bus_rdata, m_read(bus_addr));
      chk("model(R10) irq", {7'd0, irq}, {7'd0, |m_flags});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_slow_rise();
    @(posedge slow_ref);
    repeat (5) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(4'd0, v);  chk("R1 cfg reset", v, 8'h02);
    rd(4'd1, v);  chk("R1 cnt reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    wr(4'd0, 8'hFC);        // flags written 1, spares 1, cmsel 1, sync 0, stop
    rd(4'd0, v);  chk("R3 spare bits", v, 8'h08);
    chk("R2 write one no set", {5'd0, v[7:5]}, 8'h00);

    wr(4'd4, 8'd9); wr(4'd5, 8'd0);
    wr(4'd9, 8'd3); wr(4'd3, 8'd5);
    wr(4'd1, 8'd2); wr(4'd2, 8'd0);
    wr(4'd0, 8'h09);        // immediate start, low-byte compare
    rd(4'd0, v);  chk("R4 run immediate", {7'd0, v[0]}, 8'h01);
    rd(4'd1, v);  chk("R6 reload count", v, m_read(4'd1));
    repeat (40) @(posedge clk);
    rd(4'd0, v);
    chk("R8 low compare flag", {7'd0, v[7]}, 8'h01);
    chk("R7 period flag", {7'd0, v[6]}, 8'h01);
    chk("R9 ovf compare flag", {7'd0, v[5]}, 8'h01);
    chk("R10 irq set", {7'd0, irq}, 8'h01);

    wr(4'd0, 8'hE8);        // stop immediately, keep flags
    rd(4'd0, v);  chk("R2 write one keeps", v, 8'hE8);
    rd(4'd1, v); repeat (5) @(posedge clk); rd(4'd1, v2);
    chk("R11 idle hold", v2, v);
    rd(4'd6, v);  chk("R7 ovf count", v, m_read(4'd6));
    wr(4'd0, 8'h00);        // clear flags, high-byte compare
    rd(4'd0, v);  chk("R2 clear", v, 8'h00);
    chk("R10 irq clear", {7'd0, irq}, 8'h00);

    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd3, 8'd1);
    wr(4'd1, 8'hF0); wr(4'd2, 8'h00);
    wr(4'd0, 8'h01);        // start, compare bits 15:8
    repeat (5) @(posedge clk);
    rd(4'd0, v);  chk("R8 high byte no match yet", {7'd0, v[7]}, 8'h00);
    repeat (25) @(posedge clk);
    rd(4'd0, v);  chk("R8 high byte match", {7'd0, v[7]}, 8'h01);
    wr(4'd0, 8'h00);

    slow_en = 1;
    wait_slow_rise();
    wr(4'd0, 8'h03);        // deferred start
    rd(4'd0, v);  chk("R5 start lag", {7'd0, v[0]}, 8'h00);
    repeat (50) @(posedge clk);
    rd(4'd0, v);  chk("R5 start applied", {7'd0, v[0]}, 8'h01);
    wait_slow_rise();
    wr(4'd0, 8'h02);        // deferred stop
    rd(4'd0, v);  chk("R5 stop lag", {7'd0, v[0]}, 8'h01);
    repeat (50) @(posedge clk);
    rd(4'd0, v);  chk("R5 stop applied", {7'd0, v[0]}, 8'h00);
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule